// File: doc/BRIEF.md
# Active Energy Pulse Frequency Converter

This block turns a stream of signed, already calibrated active-power samples into an active-low pulse train whose rate follows the power. Each accepted sample first passes through a gain-and-offset trim. It is then screened by a no-load comparator and summed into an energy accumulator. Each time the accumulator reaches a programmable energy quantum, one output pulse is issued. The quantum is a fixed base value multiplied by a rate divider.

A single mode input chooses how energy is counted. In signed counting, reverse power subtracts energy. In magnitude counting, power of either direction adds energy, and the pulse rate follows that choice. In both modes the block keeps a direction flag and a no-load flag up to date, and it raises one-cycle strobes when either flag changes. A meter uses the pulse line to drive an indicator and uses the strobes to raise interrupts.

Top module: `apfc_top`

## Requirements
- R1: An accepted sample s gives a trimmed value c = s + floor(s*g/4096) + o. Here g is the 12-bit two's-complement gain and o is the 16-bit two's-complement offset. The trim stage adds one cycle of latency.
- R2: A trimmed value with |c| < nl_thr is never added to the accumulator, in either mode. The noload output reads 1 after such a value and 0 after a value with |c| >= nl_thr.
- R3: With abs_mode = 0, the signed value c is added, so negative power draws the accumulator down.
- R4: With abs_mode = 1, |c| is added, so negative power raises the accumulator just as positive power does.
- R5: Let T = PULSE_THR*(rate_div+1). When a sum reaches +T, T is subtracted; when it reaches -T, T is added. Either event requests one pulse, and the remainder is kept. The output falls two clock edges after the trim stage captures the sample.
- R6: pulse_n is active low and stays low for exactly PULSE_LEN cycles. A request that arrives while the pulse is low is dropped and does not extend the pulse.
- R7: sign_neg holds the sign of the last value that passed the no-load screen (1 = negative). Screened-out values leave it unchanged.
- R8: sign_evt is high for one cycle when a value that passes the screen has a sign different from sign_neg. This works in both modes.
- R9: noload_evt is high for one cycle whenever a new value changes the noload state. This works in both modes.
- R10: After reset, pulse_n = 1, sign_neg = 0, noload = 1, both strobes are 0 and the accumulator is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld | input | 1 | Sample strobe |
| smp | input | SAMPLE_W | Signed active-power sample |
| abs_mode | input | 1 | 1 = count magnitude, 0 = count signed |
| gain | input | GAIN_W | Signed gain trim, scaled by 2^-GAIN_W |
| ofs | input | OFS_W | Signed offset trim |
| nl_thr | input | NL_W | No-load magnitude threshold |
| rate_div | input | DIV_W | Energy quantum multiplier minus one |
| pulse_n | output | 1 | Active-low energy pulse |
| sign_neg | output | 1 | Power direction, 1 = reverse |
| noload | output | 1 | Last value was below the threshold |
| sign_evt | output | 1 | One-cycle direction change strobe |
| noload_evt | output | 1 | One-cycle no-load change strobe |

## Verification
The bench builds the block with PULSE_THR = 1000 and PULSE_LEN = 3. With these values, samples of a few hundred units produce a pulse every few samples. Back-to-back samples close to the quantum raise requests faster than a three-cycle pulse can clear, which tests the rule that a request arriving during a low pulse is dropped. Changing rate_div then multiplies the quantum while the remainders stay small enough to follow cycle by cycle.

// File: rtl/apfc_pkg.sv
package apfc_pkg;
  typedef enum logic {
    ACC_SIGNED = 1'b0,
    ACC_MAG    = 1'b1
  } acc_mode_e;

  localparam int unsigned SYNC_STAGES_DEF = 2;
endpackage

// File: rtl/apfc_calib.sv
module apfc_calib #(
  parameter int unsigned SAMPLE_W = 24,
  parameter int unsigned GAIN_W   = 12,
  parameter int unsigned OFS_W    = 16,
  parameter int unsigned CAL_W    = SAMPLE_W + 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_vld,
  input  logic signed [SAMPLE_W-1:0] in_smp,
  input  logic signed [GAIN_W-1:0]   gain,
  input  logic signed [OFS_W-1:0]    ofs,
  output logic                       cal_vld,
  output logic signed [CAL_W-1:0]    cal
);
  localparam int unsigned PROD_W = SAMPLE_W + GAIN_W;

  logic signed [PROD_W-1:0]   prod;
  logic signed [PROD_W-1:0]   prod_sh;
  logic signed [CAL_W-1:0]    smp_x;
  logic signed [CAL_W-1:0]    trim_x;
  logic signed [CAL_W-1:0]    ofs_x;
  logic signed [CAL_W-1:0]    cal_d;
  logic signed [CAL_W-1:0]    cal_q;
  logic                       vld_q;

  always_comb begin
    prod    = in_smp * gain;
    prod_sh = prod >>> GAIN_W;
    smp_x   = {{(CAL_W-SAMPLE_W){in_smp[SAMPLE_W-1]}}, in_smp};
    trim_x  = {{(CAL_W-SAMPLE_W){prod_sh[SAMPLE_W-1]}}, prod_sh[SAMPLE_W-1:0]};
    ofs_x   = {{(CAL_W-OFS_W){ofs[OFS_W-1]}}, ofs};
    cal_d   = cal_q;
    if (in_vld) begin
      cal_d = smp_x + trim_x + ofs_x;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cal_q <= '0;
      vld_q <= 1'b0;
    end else begin
      cal_q <= cal_d;
      vld_q <= in_vld;
    end
  end

  assign cal     = cal_q;
  assign cal_vld = vld_q;

  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> cal_vld);
  a_r1_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> $stable(cal));
endmodule

// File: rtl/apfc_noload.sv
module apfc_noload #(
  parameter int unsigned CAL_W = 26,
  parameter int unsigned NL_W  = 24
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cal_vld,
  input  logic signed [CAL_W-1:0] cal,
  input  logic                    abs_mode,
  input  logic [NL_W-1:0]         nl_thr,
  output logic                    add_vld,
  output logic signed [CAL_W-1:0] add,
  output logic                    sign_neg,
  output logic                    noload,
  output logic                    sign_evt,
  output logic                    noload_evt
);
  import apfc_pkg::*;

  logic [CAL_W-1:0]        mag;
  logic [CAL_W-1:0]        thr_x;
  logic                    loaded;
  acc_mode_e               mode;

  logic                    add_vld_d, add_vld_q;
  logic signed [CAL_W-1:0] add_d, add_q;
  logic                    sign_d, sign_q;
  logic                    nl_d, nl_q;
  logic                    sevt_d, sevt_q;
  logic                    nevt_d, nevt_q;

  always_comb begin
    mode   = acc_mode_e'(abs_mode);
    mag    = cal[CAL_W-1] ? (~cal + 1'b1) : cal;
    thr_x  = {{(CAL_W-NL_W){1'b0}}, nl_thr};
    loaded = (mag >= thr_x);

    add_vld_d = cal_vld & loaded;
    add_d     = add_q;
    sign_d    = sign_q;
    sevt_d    = 1'b0;
    nl_d      = nl_q;
    nevt_d    = 1'b0;
    if (cal_vld) begin
      nl_d   = !loaded;
      nevt_d = (nl_q == loaded);
      if (loaded) begin
        add_d  = (mode == ACC_MAG) ? $signed(mag) : cal;
        sign_d = cal[CAL_W-1];
        sevt_d = cal[CAL_W-1] ^ sign_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      add_vld_q <= 1'b0;
      add_q     <= '0;
      sign_q    <= 1'b0;
      nl_q      <= 1'b1;
      sevt_q    <= 1'b0;
      nevt_q    <= 1'b0;
    end else begin
      add_vld_q <= add_vld_d;
      add_q     <= add_d;
      sign_q    <= sign_d;
      nl_q      <= nl_d;
      sevt_q    <= sevt_d;
      nevt_q    <= nevt_d;
    end
  end

  assign add_vld    = add_vld_q;
  assign add        = add_q;
  assign sign_neg   = sign_q;
  assign noload     = nl_q;
  assign sign_evt   = sevt_q;
  assign noload_evt = nevt_q;

  a_r2_drop_small: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_vld && (mag < thr_x)) |=> (!add_vld && noload));
  a_r4_mag_positive: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_vld && !(mag < thr_x) && abs_mode) |=> (add_vld && !add[CAL_W-1]));
  a_r7_sign_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(cal_vld && !(mag < thr_x)) |=> $stable(sign_neg));
  a_r9_evt_needs_sample: assert property (@(posedge clk) disable iff (!rst_n)
    !cal_vld |=> (!sign_evt && !noload_evt));
endmodule

// File: rtl/apfc_dfc.sv
module apfc_dfc #(
  parameter int unsigned CAL_W     = 26,
  parameter int unsigned DIV_W     = 8,
  parameter int unsigned PULSE_THR = 1 << 22,
  parameter int unsigned PULSE_LEN = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    add_vld,
  input  logic signed [CAL_W-1:0] add,
  input  logic [DIV_W-1:0]        div,
  output logic                    pulse_n
);
  localparam int unsigned THR_W = $clog2(PULSE_THR + 1) + DIV_W;
  localparam int unsigned ACC_W = ((THR_W > CAL_W) ? THR_W : CAL_W) + 2;
  localparam int unsigned CNT_W = $clog2(PULSE_LEN + 1);

  logic [ACC_W-1:0]        thr_u;
  logic signed [ACC_W-1:0] thr_p;
  logic signed [ACC_W-1:0] thr_m;
  logic signed [ACC_W-1:0] add_x;
  logic signed [ACC_W-1:0] sum;
  logic signed [ACC_W-1:0] acc_d, acc_q;
  logic                    fire;
  logic [CNT_W-1:0]        cnt_d, cnt_q;

  always_comb begin
    thr_u = ACC_W'(PULSE_THR) * (ACC_W'(div) + ACC_W'(1));
    thr_p = $signed(thr_u);
    thr_m = -thr_p;
    add_x = {{(ACC_W-CAL_W){add[CAL_W-1]}}, add};
    sum   = acc_q + add_x;
    acc_d = acc_q;
    fire  = 1'b0;
    if (add_vld) begin
      if (sum >= thr_p) begin
        acc_d = sum - thr_p;
        fire  = 1'b1;
      end else if (sum <= thr_m) begin
        acc_d = sum + thr_p;
        fire  = 1'b1;
      end else begin
        acc_d = sum;
      end
    end
  end

  always_comb begin
    if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end else if (fire) begin
      cnt_d = CNT_W'(PULSE_LEN);
    end else begin
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else begin
      if (add_vld) begin
        acc_q <= acc_d;
      end
      cnt_q <= cnt_d;
    end
  end

  assign pulse_n = (cnt_q == '0);

  a_r5_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pulse_n) |-> $past(add_vld));
  a_r6_no_retrigger: assert property (@(posedge clk) disable iff (!rst_n)
    (!pulse_n && fire) |=> (cnt_q < $past(cnt_q)));
  a_r5_remainder_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (add_vld && $stable(div) && (acc_q < thr_p) && (acc_q > thr_m)
     && (add_x < thr_p) && (add_x > thr_m)) |=> ((acc_q < thr_p) && (acc_q > thr_m)));

  generate
    if (PULSE_LEN > 1) begin : g_len_chk
      a_r6_min_width: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pulse_n) |=> !pulse_n);
    end
  endgenerate
endmodule

// File: rtl/apfc_top.sv
module apfc_top #(
  parameter int unsigned SAMPLE_W    = 24,
  parameter int unsigned GAIN_W      = 12,
  parameter int unsigned OFS_W       = 16,
  parameter int unsigned NL_W        = 24,
  parameter int unsigned DIV_W       = 8,
  parameter int unsigned PULSE_THR   = 1 << 22,
  parameter int unsigned PULSE_LEN   = 16,
  parameter int unsigned SYNC_STAGES = apfc_pkg::SYNC_STAGES_DEF
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_vld,
  input  logic [SAMPLE_W-1:0] smp,
  input  logic                abs_mode,
  input  logic [GAIN_W-1:0]   gain,
  input  logic [OFS_W-1:0]    ofs,
  input  logic [NL_W-1:0]     nl_thr,
  input  logic [DIV_W-1:0]    rate_div,
  output logic                pulse_n,
  output logic                sign_neg,
  output logic                noload,
  output logic                sign_evt,
  output logic                noload_evt
);
  localparam int unsigned CAL_W = SAMPLE_W + 2;

  logic [SYNC_STAGES-1:0]  rst_pipe;
  logic                    rst_core_n;
  logic                    cal_vld;
  logic signed [CAL_W-1:0] cal;
  logic                    add_vld;
  logic signed [CAL_W-1:0] add;

  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_rst_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          rst_pipe[i] <= 1'b0;
        end else begin
          rst_pipe[i] <= (i == 0) ? 1'b1 : rst_pipe[(i == 0) ? 0 : i-1];
        end
      end
    end
  endgenerate

  assign rst_core_n = rst_pipe[SYNC_STAGES-1];

  apfc_calib #(
    .SAMPLE_W (SAMPLE_W),
    .GAIN_W   (GAIN_W),
    .OFS_W    (OFS_W),
    .CAL_W    (CAL_W)
  ) u_calib (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .in_vld  (smp_vld),
    .in_smp  ($signed(smp)),
    .gain    ($signed(gain)),
    .ofs     ($signed(ofs)),
    .cal_vld (cal_vld),
    .cal     (cal)
  );

  apfc_noload #(
    .CAL_W (CAL_W),
    .NL_W  (NL_W)
  ) u_noload (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .cal_vld    (cal_vld),
    .cal        (cal),
    .abs_mode   (abs_mode),
    .nl_thr     (nl_thr),
    .add_vld    (add_vld),
    .add        (add),
    .sign_neg   (sign_neg),
    .noload     (noload),
    .sign_evt   (sign_evt),
    .noload_evt (noload_evt)
  );

  apfc_dfc #(
    .CAL_W     (CAL_W),
    .DIV_W     (DIV_W),
    .PULSE_THR (PULSE_THR),
    .PULSE_LEN (PULSE_LEN)
  ) u_dfc (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .add_vld (add_vld),
    .add     (add),
    .div     (rate_div),
    .pulse_n (pulse_n)
  );

  a_r8_one_cycle_strobe: assert property (@(posedge clk) disable iff (!rst_core_n)
    sign_evt |=> (!sign_evt || $changed(sign_neg)));
  a_r10_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_core_n)
    $rose(rst_core_n) |-> (pulse_n && noload && !sign_neg));
endmodule

// File: tb/apfc_top_tb_top.sv
module apfc_top_tb_top;
  localparam int unsigned SW   = 24;
  localparam int unsigned THR  = 1000;
  localparam int unsigned PLEN = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_vld = 1'b0;
  logic [SW-1:0] smp = '0;
  logic abs_mode = 1'b0;
  logic [11:0] gain = '0;
  logic [15:0] ofs = '0;
  logic [23:0] nl_thr = '0;
  logic [7:0] rate_div = '0;
  logic pulse_n, sign_neg, noload, sign_evt, noload_evt;

  int total = 0;
  int bad = 0;
  bit chk_en = 1'b0;
  bit done = 1'b0;

  // behavioural reference state
  bit     m_cv = 0;   longint m_c = 0;
  bit     m_av = 0;   longint m_a = 0;
  bit     m_sign = 0; bit m_nl = 1; bit m_se = 0; bit m_ne = 0;
  longint m_acc = 0;  int m_cnt = 0;

  always #10 clk = ~clk;

  apfc_top #(.PULSE_THR(THR), .PULSE_LEN(PLEN)) dut_i (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp(smp),
    .abs_mode(abs_mode), .gain(gain), .ofs(ofs), .nl_thr(nl_thr),
    .rate_div(rate_div), .pulse_n(pulse_n), .sign_neg(sign_neg),
    .noload(noload), .sign_evt(sign_evt), .noload_evt(noload_evt)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cv = 0; m_c = 0; m_av = 0; m_a = 0; m_sign = 0; m_nl = 1;
      m_se = 0; m_ne = 0; m_acc = 0; m_cnt = 0;
    end else begin
      longint t, s2, mag;
      bit f;
      // accumulate and pulse (R3 R4 R5 R6)
      t = longint'(THR) * (longint'(rate_div) + 1);
      f = 0;
      if (m_av) begin
        s2 = m_acc + m_a;
        if (s2 >= t) begin s2 = s2 - t; f = 1; end
        else if (s2 <= -t) begin s2 = s2 + t; f = 1; end
        m_acc = s2;
      end
      if (m_cnt != 0) m_cnt = m_cnt - 1;
      else if (f) m_cnt = PLEN;
      // no-load screen, sign and events (R2 R7 R8 R9)
      m_av = 0; m_se = 0; m_ne = 0;
      if (m_cv) begin
        mag = (m_c < 0) ? -m_c : m_c;
        if (mag >= longint'(nl_thr)) begin
          if (m_nl) m_ne = 1;
          m_nl = 0;
          if ((m_c < 0) != m_sign) m_se = 1;
          m_sign = (m_c < 0);
          m_av = 1;
          m_a = abs_mode ? mag : m_c;
        end else begin
          if (!m_nl) m_ne = 1;
          m_nl = 1;
        end
      end
      // trim (R1)
      m_cv = smp_vld;
      if (smp_vld)
        m_c = longint'($signed(smp)) + ((longint'($signed(smp)) * longint'($signed(gain))) >>> 12)
              + longint'($signed(ofs));
    end
  end

  task automatic chk(input string tag, input longint got, input longint exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (chk_en) begin
      chk("R5 R6 pulse_n", pulse_n, (m_cnt == 0));
      chk("R7 sign_neg", sign_neg, m_sign);
      chk("R2 noload", noload, m_nl);
      chk("R8 sign_evt", sign_evt, m_se);
      chk("R9 noload_evt", noload_evt, m_ne);
    end
  end

  task automatic put(input int s, input bit v);
    @(negedge clk);
    smp_vld = v;
    smp = SW'(s);
  endtask

  task automatic run(input int s, input int n);
    for (int i = 0; i < n; i++) put(s, 1'b1);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) put(0, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 pulse_n", pulse_n, 1);
    chk("R10 sign_neg", sign_neg, 0);
    chk("R10 noload", noload, 1);
    chk("R10 strobes", {sign_evt, noload_evt}, 0);
    chk_en = 1'b1;
    // R3 signed positive stream, R5 remainder carry
    run(300, 20); idle(6);
    // R1 gain and offset trim
    gain = 12'(-512); ofs = 16'(40); run(350, 12); idle(4);
    gain = 12'(1024); ofs = 16'(-30); run(-250, 12); idle(4);
    gain = '0; ofs = '0;
    // R3 alternating signs cancel in signed mode, R8 strobes
    for (int i = 0; i < 16; i++) put((i % 2) ? -400 : 450, 1'b1);
    idle(4);
    // R2 no-load screen, R9 transitions
    nl_thr = 24'd100;
    run(60, 8); run(-80, 5); run(500, 4); run(-20, 3); run(700, 3); idle(6);
    // R4 magnitude mode with reverse power, R8 still active
    abs_mode = 1'b1;
    run(-450, 12); run(450, 6); run(-50, 4); idle(6);
    abs_mode = 1'b0;
    // R6 requests while low are dropped
    run(900, 20); idle(8);
    run(-950, 10); idle(6);
    // R5 larger quantum via rate_div
    rate_div = 8'd3; run(700, 24); idle(6);
    // mixed random stream
    for (int i = 0; i < 600; i++) begin
      if ((i % 150) == 0) begin
        abs_mode = $urandom_range(0, 1);
        rate_div = 8'($urandom_range(0, 2));
        nl_thr = 24'($urandom_range(0, 200));
      end
      put($urandom_range(0, 1800) - 900, $urandom_range(0, 3) != 0);
    end
    idle(8);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule